// File: doc/BRIEF.md
# Speculative Loop Dependence Checker

This block judges, after the fact, whether a loop that ran speculatively in parallel was free of cross-iteration dependences on a single array of `ELEMS` elements. While the loop runs, it watches a stream of element accesses. Each access carries an element index and a read/write flag. A separate strobe marks where each iteration ends. For every element the block keeps a write mark and a read mark, and it keeps a running total of distinct writes summed over the iterations.

A read leaves a mark only when the same iteration has not already written that element. A value that an iteration produces and then consumes itself is therefore not a dependence. When a start pulse arrives, the block walks the marks one element per clock. It counts the elements that carry a write mark, and it notes any element that carries both marks. When the walk ends, it reports a one-cycle completion pulse and a verdict. The verdict is parallel only when no element carries both marks and the summed per-iteration write counts equal the number of write-marked elements.

A clear input returns the block to its empty setup state between loops.

Top module: `dep_shadow_checker`

## Requirements
- R1: After reset or `clr`, `busy`, `done` and `parallel_ok` are 0. All marks and the write total are empty, so a following analysis reports `parallel_ok`=1.
- R2: A write access (`acc_write`=1) puts a write mark on its element. The element then counts once toward the marked-writes figure, however often it is written.
- R3: A read access (`acc_write`=0) puts a read mark on its element only if that element has not been written earlier in the current iteration or in the same cycle. A read after a write in the same iteration leaves the verdict parallel. A read before a write in the same iteration makes it fail.
- R4: A read in one iteration combined with a write to the same element in another iteration, in either order, makes the verdict fail.
- R5: At each `iter_end`, the number of distinct elements written in that iteration is added to the write total. An access in the same cycle belongs to the ending iteration. Two iterations writing one element fail the verdict. Repeated writes inside one iteration do not fail it.
- R6: Writes of an iteration that has not been closed by `iter_end` are missing from the total, so the verdict fails until that strobe arrives.
- R7: Timing of the walk. A start pulse accepted at clock edge E raises `busy` from E to E+`ELEMS`. `done` is high for exactly the one cycle after edge E+`ELEMS`. `parallel_ok` changes only together with `done` (or on clear) and holds its value otherwise.
- R8: Accesses and `iter_end` strobes that arrive while `busy` is 1 have no effect on any later verdict.
- R9: A start pulse while `busy` is 1 is ignored. The walk in progress finishes on time and produces a single `done`.
- R10: Elements that are only read, in any number of iterations, never cause the verdict to fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous return to the empty setup state |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_idx | input | $clog2(ELEMS) | Element index of the access |
| iter_end | input | 1 | Ends the current iteration |
| analyze_start | input | 1 | Starts the analysis walk |
| busy | output | 1 | Analysis walk in progress |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| parallel_ok | output | 1 | Verdict: 1 = loop is parallel, 0 = dependence found |

## Verification
Marks and the write total take effect at the same edge that samples the access or strobe. Their effect only becomes visible at the ports through a later verdict, so each scenario closes with an analysis, and the verdict is compared in the cycle in which `done` is high. The bench records the cycle in which it drives the start pulse and requires `done` exactly `ELEMS`+1 falling edges later, while a behavioural model checks `busy`, `done` and `parallel_ok` at every falling edge. Stimulus injected during a walk is followed by a second analysis, so the bench can show that the earlier verdict is unchanged.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } acc_op_e;

  function automatic int unsigned cnt_width(input int unsigned elems, input int unsigned iters);
    return $clog2(elems * iters + 1);
  endfunction
endpackage

// File: rtl/dsc_shadow_bits.sv
module dsc_shadow_bits #(
  parameter int ELEMS = 64,
  localparam int IDX_W = $clog2(ELEMS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set_wr,
  input  logic             set_rd,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] scan_idx,
  output logic             scan_wr,
  output logic             scan_rd
);
  logic wr_mark [ELEMS];
  logic rd_mark [ELEMS];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int k = 0; k < ELEMS; k++) begin
        wr_mark[k] <= 1'b0;
        rd_mark[k] <= 1'b0;
      end
    end else begin
      if (set_wr) wr_mark[set_idx] <= 1'b1;
      if (set_rd) rd_mark[set_idx] <= 1'b1;
    end
  end

  assign scan_wr = wr_mark[scan_idx];
  assign scan_rd = rd_mark[scan_idx];
endmodule

// File: rtl/dsc_iter_tracker.sv
module dsc_iter_tracker #(
  parameter int ELEMS = 64,
  parameter int CNT_W = 17,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int ITC_W = $clog2(ELEMS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             close_en,
  output logic             seen_here,
  output logic [CNT_W-1:0] total_writes
);
  logic [ELEMS-1:0] seen_q;
  logic [ITC_W-1:0] iter_cnt_q;
  logic [ITC_W-1:0] iter_cnt_nx;
  logic             fresh_wr;

  assign seen_here   = seen_q[acc_idx];
  assign fresh_wr    = acc_en && acc_wr && !seen_q[acc_idx];
  assign iter_cnt_nx = iter_cnt_q + ITC_W'(fresh_wr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen_q       <= '0;
      iter_cnt_q   <= '0;
      total_writes <= '0;
    end else if (close_en) begin
      seen_q       <= '0;
      iter_cnt_q   <= '0;
      total_writes <= total_writes + CNT_W'(iter_cnt_nx);
    end else begin
      if (fresh_wr) seen_q[acc_idx] <= 1'b1;
      iter_cnt_q <= iter_cnt_nx;
    end
  end
endmodule

// File: rtl/dsc_scan_engine.sv
module dsc_scan_engine #(
  parameter int ELEMS = 64,
  parameter int CNT_W = 17,
  localparam int IDX_W = $clog2(ELEMS),
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ELEMS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start_en,
  input  logic             scan_wr,
  input  logic             scan_rd,
  input  logic [CNT_W-1:0] total_writes,
  output logic [IDX_W-1:0] scan_idx,
  output logic             busy,
  output logic             done,
  output logic             verdict
);
  logic [CNT_W-1:0] marked_q;
  logic [CNT_W-1:0] marked_nx;
  logic             clash_q;
  logic             clash_nx;

  assign marked_nx = marked_q + CNT_W'(scan_wr);
  assign clash_nx  = clash_q | (scan_wr & scan_rd);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      verdict  <= 1'b0;
      scan_idx <= '0;
      marked_q <= '0;
      clash_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        marked_q <= marked_nx;
        clash_q  <= clash_nx;
        if (scan_idx == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          verdict <= !clash_nx && (marked_nx == total_writes);
        end else begin
          scan_idx <= scan_idx + 1'b1;
        end
      end else if (start_en) begin
        busy     <= 1'b1;
        scan_idx <= '0;
        marked_q <= '0;
        clash_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dep_shadow_checker.sv
module dep_shadow_checker #(
  parameter int ELEMS     = 64,
  parameter int MAX_ITERS = 1024,
  localparam int IDX_W = $clog2(ELEMS),
  localparam int CNT_W = dsc_pkg::cnt_width(ELEMS, MAX_ITERS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             iter_end,
  input  logic             analyze_start,
  output logic             busy,
  output logic             done,
  output logic             parallel_ok
);
  import dsc_pkg::*;

  acc_op_e          op;
  logic             acc_en;
  logic             close_en;
  logic             start_en;
  logic             seen_here;
  logic [CNT_W-1:0] total_writes;
  logic [IDX_W-1:0] scan_idx;
  logic             scan_wr;
  logic             scan_rd;

  assign op       = acc_op_e'(acc_write);
  assign acc_en   = acc_valid && !busy;
  assign close_en = iter_end && !busy;
  assign start_en = analyze_start && !busy;

  dsc_iter_tracker #(.ELEMS(ELEMS), .CNT_W(CNT_W)) u_iter (
    .clk(clk), .rst(rst), .clr(clr),
    .acc_en(acc_en), .acc_wr(op == OP_WRITE), .acc_idx(acc_idx),
    .close_en(close_en), .seen_here(seen_here), .total_writes(total_writes)
  );

  dsc_shadow_bits #(.ELEMS(ELEMS)) u_marks (
    .clk(clk), .rst(rst), .clr(clr),
    .set_wr(acc_en && op == OP_WRITE),
    .set_rd(acc_en && op == OP_READ && !seen_here),
    .set_idx(acc_idx), .scan_idx(scan_idx),
    .scan_wr(scan_wr), .scan_rd(scan_rd)
  );

  dsc_scan_engine #(.ELEMS(ELEMS), .CNT_W(CNT_W)) u_scan (
    .clk(clk), .rst(rst), .clr(clr), .start_en(start_en),
    .scan_wr(scan_wr), .scan_rd(scan_rd), .total_writes(total_writes),
    .scan_idx(scan_idx), .busy(busy), .done(done), .verdict(parallel_ok)
  );
endmodule

// File: rtl/dep_shadow_checker_sva.sv
module dep_shadow_checker_sva #(
  parameter int ELEMS = 64
) (
  input logic clk,
  input logic rst,
  input logic clr,
  input logic analyze_start,
  input logic busy,
  input logic done,
  input logic parallel_ok
);
  localparam int RUN_W = $clog2(ELEMS + 2);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || clr || !busy) run_len <= '0;
    else                     run_len <= run_len + 1'b1;
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_walk_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> !busy && $past(busy));

  p_walk_needs_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(analyze_start));

  p_walk_length_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_len < RUN_W'(ELEMS));

  p_verdict_held_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(parallel_ok) |-> done || $past(clr));

  p_clear_idle_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> !busy && !done && !parallel_ok);
endmodule

bind dep_shadow_checker dep_shadow_checker_sva #(.ELEMS(ELEMS)) u_sva (
  .clk(clk), .rst(rst), .clr(clr), .analyze_start(analyze_start),
  .busy(busy), .done(done), .parallel_ok(parallel_ok)
);

// File: tb/sim_dep_shadow_checker.sv
module sim_dep_shadow_checker;
  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_write = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic iter_end = 1'b0;
  logic analyze_start = 1'b0;
  logic busy, done, parallel_ok;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dep_shadow_checker #(.ELEMS(N), .MAX_ITERS(16)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_idx(acc_idx), .iter_end(iter_end), .analyze_start(analyze_start),
    .busy(busy), .done(done), .parallel_ok(parallel_ok)
  );

  // behavioural reference model
  bit m_wr[N], m_rd[N], m_seen[N];
  int m_iter, m_total, m_pos, m_marked;
  bit m_clash, m_busy, m_done, m_ok;

  always @(posedge clk) begin
    cyc++;
    if (rst || clr) begin
      foreach (m_wr[k]) begin m_wr[k] = 0; m_rd[k] = 0; m_seen[k] = 0; end
      m_iter = 0; m_total = 0; m_busy = 0; m_done = 0; m_ok = 0;
      m_pos = 0; m_marked = 0; m_clash = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_wr[m_pos]) m_marked++;
        if (m_wr[m_pos] && m_rd[m_pos]) m_clash = 1;
        if (m_pos == N - 1) begin
          m_busy = 0; m_done = 1;
          m_ok = !m_clash && (m_marked == m_total);
        end else m_pos++;
      end else begin
        if (acc_valid) begin
          if (acc_write) begin
            m_wr[acc_idx] = 1;
            if (!m_seen[acc_idx]) begin m_seen[acc_idx] = 1; m_iter++; end
          end else if (!m_seen[acc_idx]) m_rd[acc_idx] = 1;
        end
        if (iter_end) begin
          m_total += m_iter; m_iter = 0;
          foreach (m_seen[k]) m_seen[k] = 0;
        end
        if (analyze_start) begin
          m_busy = 1; m_pos = 0; m_marked = 0; m_clash = 0;
        end
      end
    end
  end

  task automatic check(input bit got, input bit exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (cycle %0d)", what, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy, m_busy, "R7 busy vs model");
      check(done, m_done, "R7 done vs model");
      check(parallel_ok, m_ok, "R7 verdict vs model");
    end
  end

  task automatic drive(input bit v, input bit w, input int i, input bit e, input bit s);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_idx = IW'(i); iter_end = e; analyze_start = s;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int i, input bit e);
    drive(1, 1, i, e, 0);
  endtask

  task automatic rd(input int i, input bit e);
    drive(1, 0, i, e, 0);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1;
    acc_valid = 0; iter_end = 0; analyze_start = 0;
    @(negedge clk); clr = 0;
  endtask

  int t_kick;
  task automatic kick();
    drive(0, 0, 0, 0, 1);
    t_kick = cyc;
  endtask

  task automatic finish_walk(input bit exp, input string what);
    idle();
    while (done !== 1'b1) @(negedge clk);
    checks++;
    if (cyc - t_kick != N + 1) begin
      errors++;
      $display("FAIL R7 done latency: actual=%0d expected=%0d", cyc - t_kick, N + 1);
    end
    check(parallel_ok, exp, what);
  endtask

  task automatic analyze(input bit exp, input string what);
    kick();
    finish_walk(exp, what);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy, 0, "R1 busy after reset");
    check(done, 0, "R1 done after reset");
    check(parallel_ok, 0, "R1 verdict after reset");
    analyze(1, "R1 empty state is parallel");

    // R2 R3 R5: repeated write and read-after-write within one iteration
    wr(3, 0); wr(3, 0); rd(3, 1); wr(5, 1);
    analyze(1, "R3 read after own write stays parallel");

    do_clear();
    check(parallel_ok, 0, "R1 verdict cleared");
    wr(2, 1); wr(2, 1);
    analyze(0, "R5 two iterations writing one element fail");

    do_clear();
    rd(4, 0); wr(4, 1);
    analyze(0, "R3 read before write in one iteration fails");

    do_clear();
    rd(6, 1); wr(6, 1);
    analyze(0, "R4 read then write across iterations fails");

    do_clear();
    wr(6, 1); rd(6, 1);
    analyze(0, "R4 write then read across iterations fails");

    do_clear();
    wr(1, 0); wr(9, 0);
    analyze(0, "R6 unclosed iteration fails");
    drive(0, 0, 0, 1, 0);
    analyze(1, "R6 closing the iteration restores parallel");

    do_clear();
    rd(0, 0); rd(1, 0); rd(2, 1); rd(0, 1); rd(1, 0); wr(9, 1);
    analyze(1, "R10 read-only elements stay parallel");

    // R8: access during a walk is ignored
    do_clear();
    wr(7, 1);
    kick();
    wr(8, 0); rd(7, 0);
    finish_walk(1, "R8 walk verdict");
    analyze(1, "R8 access during walk ignored");

    // R8: iteration close during a walk is ignored
    do_clear();
    wr(7, 0);
    kick();
    drive(0, 0, 0, 1, 0);
    finish_walk(0, "R8 walk verdict unclosed");
    analyze(0, "R8 iter_end during walk ignored");

    // R9: start during a walk ignored, timing unchanged
    do_clear();
    wr(12, 1);
    kick();
    idle(); idle();
    drive(0, 0, 0, 0, 1);
    finish_walk(1, "R9 restart ignored");
    idle(); idle();
    check(done, 0, "R9 no second done");

    // R1: clear in mid-walk
    kick();
    idle(); idle();
    do_clear();
    check(busy, 0, "R1 clear stops walk");
    repeat (N + 2) begin
      @(negedge clk);
      checks++;
      if (done !== 1'b0) begin
        errors++;
        $display("FAIL R1 done after clear: actual=%0b expected=0", done);
      end
    end

    idle(); idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule